// File: doc/BRIEF.md
# Serial Field-Memory Write Port

This block is the write-side controller of a serial field memory that behaves as a digital delay line. On each rising edge of the write clock it samples four controls and a data word. These are a write-reset request, a write enable that gates the address pointer, an input enable that masks only the store, and the input data. From them it decides whether its write address pointer returns to zero, advances or holds.

Captured words pass through a one-entry staging register before they reach a plain synchronous RAM outside the block. The RAM is driven with a single-cycle strobe, an address and a data word. A captured word stays in staging until the next active write cycle or the next honoured write reset pushes it out. The RAM therefore always sees the word one write behind the pointer, and the final word of a field is committed only when the next field's reset arrives.

Two single-cycle flags report protocol misuse. One marks a reset request that comes too soon after the previous one; that request is not honoured. The other marks a field that held too few active cycles when the next reset was honoured.

Top module: `fieldmem_wr_port`

## Requirements
- R1: After system reset (`rst` high, synchronous), `ram_we`, `err_early_rst` and `err_short_seq` are 0. The first write-reset request that follows is honoured without any idle gap.
- R2: A write-reset request sampled high on a rising edge, once at least GAP (default 2) low samples of the request have occurred since the previous high sample, is honoured. After it the pointer is 0, so the next captured word is stored at address 0.
- R3: In an honoured reset cycle, `wr_en`, `in_en` and `wr_din` have no effect: nothing is captured and the pointer is not advanced.
- R4: A request sampled high with fewer than GAP low samples since the previous high sample is not honoured. It raises `err_early_rst` for exactly the following cycle, and that cycle acts as an ordinary cycle under `wr_en` and `in_en`.
- R5: On a non-reset edge with `wr_en` high, `wr_din` is captured at the current pointer and the pointer increments by one. With `wr_en` low, the pointer holds and nothing is captured.
- R6: A word captured with `in_en` low produces no RAM strobe for its address. The pointer still advances past that address.
- R7: A captured word is presented to the RAM as one `ram_we` cycle, carrying `ram_addr` equal to its capture address and `ram_wdata` equal to its data. That cycle immediately follows the next active write edge or the next honoured reset edge. Until then, no strobe is issued for it.
- R8: At an honoured reset, `err_short_seq` pulses for one cycle if fewer than MIN_ACTIVE (default 150) active write cycles occurred since the previous honoured reset. It does not pulse for the first honoured reset after system reset.
- R9: The pointer wraps from 2^ADDR_W-1 to 0 on the next active write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_rst_req | input | 1 | Write-pointer reset request, sampled on the rising edge |
| wr_en | input | 1 | Capture and pointer-advance enable |
| in_en | input | 1 | Store mask; low keeps the addressed cell unchanged |
| wr_din | input | DATA_W | Input data word |
| ram_we | output | 1 | Single-cycle RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| err_early_rst | output | 1 | Pulse: reset request rejected as too early |
| err_short_seq | output | 1 | Pulse: previous field held too few active cycles |

## Verification
A corrupt pointer is not visible at once. It shows up at the next commit, one active write later, as a strobe carrying a wrong `ram_addr`. A stale or lost staging entry shows up at the same moment as a wrong data word, or as an extra or missing strobe. Wrong reset-gap or field-length counters show up only at the next reset request, as a flag pulse that is wrong or absent in the cycle after it. The scoreboard therefore compares every strobe and checks both flags on every cycle, so each fault is caught within one or two cycles of the edge where it first becomes observable.

// File: rtl/fmwp_pkg.sv
package fmwp_pkg;

    // Per-edge decision made from the sampled write controls.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_RESET = 2'd1,
        CMD_WRITE = 2'd2
    } wcmd_e;

    // Saturating increment toward a limit.
    function automatic int unsigned sat_next(input int unsigned cur, input int unsigned lim);
        return (cur >= lim) ? lim : cur + 1;
    endfunction

endpackage

// File: rtl/fmwp_rst_qual.sv
module fmwp_rst_qual
    import fmwp_pkg::*;
#(
    parameter int unsigned GAP = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  logic  wr_en,
    output wcmd_e cmd,
    output logic  early
);
    localparam int unsigned GW = $clog2(GAP + 1);

    logic [GW-1:0] low_cnt;
    logic          armed;

    assign armed = (low_cnt >= GW'(GAP));

    // Counts low samples of the request since its last high sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= GW'(GAP);
        end else if (req) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= GW'(sat_next(int'(low_cnt), GAP));
        end
    end

    always_comb begin
        early = req && !armed;
        if (req && armed) begin
            cmd = CMD_RESET;
        end else if (wr_en) begin
            cmd = CMD_WRITE;
        end else begin
            cmd = CMD_IDLE;
        end
    end

    // An honoured reset can never be followed by another one on the next edge.
    p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RESET) |=> (cmd != CMD_RESET));

endmodule

// File: rtl/fmwp_seq_mon.sv
module fmwp_seq_mon
    import fmwp_pkg::*;
#(
    parameter int unsigned MIN_ACTIVE = 150
) (
    input  logic  clk,
    input  logic  rst,
    input  wcmd_e cmd,
    output logic  err_short
);
    localparam int unsigned CW = $clog2(MIN_ACTIVE + 1);

    logic [CW-1:0] act_cnt;
    logic          seq_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cnt   <= '0;
            seq_open  <= 1'b0;
            err_short <= 1'b0;
        end else begin
            err_short <= 1'b0;
            case (cmd)
                CMD_RESET: begin
                    err_short <= seq_open && (act_cnt < CW'(MIN_ACTIVE));
                    act_cnt   <= '0;
                    seq_open  <= 1'b1;
                end
                CMD_WRITE: act_cnt <= CW'(sat_next(int'(act_cnt), MIN_ACTIVE));
                default:   act_cnt <= act_cnt;
            endcase
        end
    end

    p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (rst)
        act_cnt <= CW'(MIN_ACTIVE));

    p_short_needs_reset_r8: assert property (@(posedge clk) disable iff (rst)
        err_short |-> $past(cmd == CMD_RESET));

endmodule

// File: rtl/fmwp_stage.sv
module fmwp_stage
    import fmwp_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  wcmd_e             cmd,
    input  logic              in_en,
    input  logic [DATA_W-1:0] din,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    typedef struct packed {
        logic              store;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stage_t;

    logic [ADDR_W-1:0] ptr;
    stage_t            stg;
    logic              pend;
    logic              commit;

    // Staged word leaves on any edge that is a reset or an active write.
    assign commit = pend && (cmd != CMD_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            pend <= 1'b0;
            stg  <= '0;
        end else begin
            case (cmd)
                CMD_RESET: begin
                    ptr  <= '0;
                    pend <= 1'b0;
                end
                CMD_WRITE: begin
                    stg  <= '{store: in_en, addr: ptr, data: din};
                    pend <= 1'b1;
                    ptr  <= ptr + 1'b1;
                end
                default: ptr <= ptr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= commit && stg.store;
            if (commit) begin
                ram_addr  <= stg.addr;
                ram_wdata <= stg.data;
            end
        end
    end

    p_reset_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RESET) |=> (ptr == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IDLE) |=> $stable(ptr));

    p_advance_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRITE) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    p_strobe_cause_r7: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(cmd != CMD_IDLE));

endmodule

// File: rtl/fieldmem_wr_port.sv
module fieldmem_wr_port
    import fmwp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned GAP        = 2,
    parameter int unsigned MIN_ACTIVE = 150
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rst_req,
    input  logic              wr_en,
    input  logic              in_en,
    input  logic [DATA_W-1:0] wr_din,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              err_early_rst,
    output logic              err_short_seq
);
    wcmd_e cmd;
    logic  early;

    fmwp_rst_qual #(.GAP(GAP)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .req   (wr_rst_req),
        .wr_en (wr_en),
        .cmd   (cmd),
        .early (early)
    );

    fmwp_seq_mon #(.MIN_ACTIVE(MIN_ACTIVE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .err_short (err_short_seq)
    );

    fmwp_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .in_en     (in_en),
        .din       (wr_din),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_early_rst <= 1'b0;
        end else begin
            err_early_rst <= early;
        end
    end

    // A rejected request and an honoured one cannot coincide (R4, R8).
    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(err_early_rst && err_short_seq));

    p_early_from_req_r4: assert property (@(posedge clk) disable iff (rst)
        err_early_rst |-> $past(wr_rst_req));

endmodule

// File: tb/fieldmem_wr_port_tb.sv
`timescale 1ns/1ps
module fieldmem_wr_port_tb;
    localparam int AW  = 8;
    localparam int DW  = 12;
    localparam int GP  = 2;
    localparam int MIN = 20;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_rst_req = 1'b0;
    logic          wr_en = 1'b0;
    logic          in_en = 1'b0;
    logic [DW-1:0] wr_din = '0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          err_early_rst;
    logic          err_short_seq;

    int checks = 0;
    int errors = 0;

    item_t exp_q[$];

    // Requirement model state
    int            m_lc;
    logic [AW-1:0] m_ptr;
    logic          m_pend;
    item_t         m_stg;
    logic          m_store;
    int            m_cnt;
    logic          m_open;

    always #10 clk = ~clk;

    fieldmem_wr_port #(.ADDR_W(AW), .DATA_W(DW), .GAP(GP), .MIN_ACTIVE(MIN)) u_dut (
        .clk(clk), .rst(rst), .wr_rst_req(wr_rst_req), .wr_en(wr_en), .in_en(in_en),
        .wr_din(wr_din), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .err_early_rst(err_early_rst), .err_short_seq(err_short_seq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: every strobe must match the head of the expectation queue (R7, R6, R5).
    always @(posedge clk) begin
        #1;
        if (!rst && ram_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R7 unexpected strobe", int'(ram_addr), -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(ram_addr == e.a, "R7 addr", int'(ram_addr), int'(e.a));
                chk(ram_wdata == e.d, "R7 data", int'(ram_wdata), int'(e.d));
            end
        end
    end

    // Driver: applies one edge worth of inputs and updates the requirement model.
    task automatic step(input logic req, input logic we, input logic ie, input logic [DW-1:0] d);
        logic ok, e_early, e_short;
        @(negedge clk);
        wr_rst_req = req; wr_en = we; in_en = ie; wr_din = d;
        ok      = req && (m_lc >= GP);        // R2
        e_early = req && !(m_lc >= GP);       // R4
        e_short = ok && m_open && (m_cnt < MIN); // R8
        if (ok) begin                          // R3: enables ignored
            if (m_pend && m_store) exp_q.push_back(m_stg);
            m_pend = 1'b0; m_ptr = '0; m_cnt = 0; m_open = 1'b1;
        end else if (we) begin                 // R5
            if (m_pend && m_store) exp_q.push_back(m_stg);
            m_stg = '{a: m_ptr, d: d}; m_store = ie; m_pend = 1'b1;
            m_ptr = m_ptr + 1'b1;              // R9 wraps
            if (m_cnt < MIN) m_cnt++;
        end
        m_lc = req ? 0 : ((m_lc < GP) ? m_lc + 1 : m_lc);
        @(posedge clk); #1;
        chk(err_early_rst == e_early, "R4 early flag", int'(err_early_rst), int'(e_early));
        chk(err_short_seq == e_short, "R8 short flag", int'(err_short_seq), int'(e_short));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(200000 * 20);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_lc = GP; m_ptr = '0; m_pend = 1'b0; m_stg = '0; m_store = 1'b0;
        m_cnt = 0; m_open = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(ram_we == 1'b0, "R1 reset we", int'(ram_we), 0);
        chk(err_early_rst == 1'b0, "R1 reset early", int'(err_early_rst), 0);
        chk(err_short_seq == 1'b0, "R1 reset short", int'(err_short_seq), 0);
        @(negedge clk); rst = 1'b0;

        // R1/R3: first request honoured at once, enables high but ignored
        step(1'b1, 1'b1, 1'b1, 12'hBAD);
        idle(2);
        // R2/R5/R6: writes from address 0, one hold, one masked
        step(1'b0, 1'b1, 1'b1, 12'hA00);
        step(1'b0, 1'b1, 1'b1, 12'hA01);
        step(1'b0, 1'b0, 1'b1, 12'hFFF);   // R5 hold
        step(1'b0, 1'b1, 1'b0, 12'hA02);   // R6 masked
        step(1'b0, 1'b1, 1'b1, 12'hA03);
        step(1'b0, 1'b1, 1'b1, 12'hA04);
        idle(4);                           // R7: last word stays pending
        chk(exp_q.size() == 0, "R7 pending held", exp_q.size(), 0);
        step(1'b1, 1'b0, 1'b0, '0);        // R7 flush, R8 short
        step(1'b1, 1'b1, 1'b1, 12'hB00);   // R4 early: acts as a write at 0
        idle(2);
        step(1'b1, 1'b1, 1'b1, 12'hCCC);   // R2 honoured, R8 short, R3
        // R9: long field crossing the wrap
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1, (i % 7) != 3, DW'(i * 5 + 1));
        idle(2);
        step(1'b1, 1'b0, 1'b0, '0);        // R8 no short
        // R8 boundary: MIN-1 then MIN active cycles
        for (int i = 0; i < MIN - 1; i++) step(1'b0, 1'b1, 1'b1, DW'(12'h300 + i));
        step(1'b1, 1'b0, 1'b0, '0);        // short expected
        for (int i = 0; i < MIN; i++) step(1'b0, 1'b1, 1'b1, DW'(12'h400 + i));
        idle(1);
        step(1'b1, 1'b0, 1'b0, '0);        // GAP not met here? model decides (R4)
        idle(2);
        step(1'b1, 1'b0, 1'b0, '0);
        idle(3);
        chk(exp_q.size() == 0, "R7 all committed", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule